// File: doc/BRIEF.md
# DDR3 Burst Column Order Generator

This block turns one read or write command into the sequence of column offsets that a DDR3-style burst visits, one data beat per clock. A static mode setting picks the ordering (sequential wrap or interleaved) and the length policy: fixed length 8, fixed chop-4, or a per-command choice. Each accepted command starts an eight-beat window. In that window the block presents the column offset of the current beat, a drive flag that is low on beats whose data lanes must float or are don't-care, and a flag on the final beat.

For writes, the block also reports whether the internal write may start two cycles early. That holds only when chop-4 is forced by the mode setting, not when chop-4 is chosen per command. Write bursts do not follow the start column. A chop-4 write uses only the top start bit to pick a group of four. A length-8 write always walks 0 to 7.

The mode inputs, the chop bit and the start column are all sampled together with the accepted command. They stay in force for the whole burst.

Top module: `burst_order_gen`

## Requirements
- R1: After reset, and while no burst is running, `busy`, `beat_drive`, `beat_last` and `wr_early` are 0.
- R2: A command accepted at a rising edge shows beat 0 right after that edge. `busy` then stays high for exactly 8 cycles, and `beat_last` is 1 only on the eighth beat (beat index 7).
- R3: A command that arrives while `busy` is high is ignored. The running burst keeps its columns and does not get longer.
- R4: With `order_sel`=0 and a length-8 read, beat i uses bit 2 = start[2] XOR i[2] and low bits = (start[1:0]+i) mod 4. For example, start 5 gives 5,6,7,4,1,2,3,0. `beat_drive` is 1 on all eight beats.
- R5: With `order_sel`=1 and a length-8 read, beat i has column start XOR i. For example, start 3 gives 3,2,1,0,7,6,5,4.
- R6: `len_sel` encodes the length policy: 00 is fixed length 8, 10 is fixed chop-4, and 11 acts as length 8. With 01, the per-command `cmd_chop` chooses: 0 gives chop-4 and 1 gives length 8.
- R7: A chop-4 read gives the same first four columns as the length-8 read of the same ordering, and `beat_drive` is 0 on beats 4 to 7.
- R8: A chop-4 write gives 0,1,2,3 when start[2]=0 and 4,5,6,7 when start[2]=1, whatever start[1:0] and `order_sel` are. `beat_drive` is 0 on beats 4 to 7.
- R9: A length-8 write gives 0 through 7 in order for any start column and either ordering, with `beat_drive` 1 on all eight beats.
- R10: `wr_early` is 1 throughout a write burst whose chop-4 comes from `len_sel`=10. It is 0 for reads, for length-8 writes, and for writes where chop-4 was chosen per command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| order_sel | input | 1 | 0 sequential wrap, 1 interleaved |
| len_sel | input | 2 | Length policy (see R6) |
| cmd_valid | input | 1 | Command strobe |
| cmd_write | input | 1 | 1 write, 0 read |
| cmd_col | input | 3 | Starting column offset |
| cmd_chop | input | 1 | Per-command chop select, used with `len_sel`=01 |
| busy | output | 1 | Burst in progress |
| beat_col | output | 3 | Column offset of the current beat |
| beat_drive | output | 1 | Data lanes driven or valid on this beat |
| beat_last | output | 1 | Final beat of the burst |
| wr_early | output | 1 | Internal write may start two cycles early |

## Verification
All outputs come from registers. Beat 0 is therefore due on the first falling edge after the rising edge that accepts the command, and beat k is due k cycles after that. The busy drop is due on the ninth falling edge after acceptance. The driver pushes the eight expected beats into a queue before that edge, and the monitor pops one item at every falling edge where `busy` is high. Column values are compared only on beats whose drive flag is expected high. The driver separately confirms that `busy` is low exactly nine falling edges after acceptance, including when a second command arrives in the middle of a burst.

// File: rtl/burst_order_pkg.sv
package burst_order_pkg;

   typedef enum logic [1:0] {
      LEN_FIX8 = 2'b00,
      LEN_OTF  = 2'b01,
      LEN_FIX4 = 2'b10,
      LEN_RSVD = 2'b11
   } len_mode_e;

   typedef enum logic {
      ORD_SEQ   = 1'b0,
      ORD_INTLV = 1'b1
   } ord_e;

   typedef struct packed {
      logic wr;
      logic chop;
      logic early;
      ord_e ord;
   } burst_ctx_t;

endpackage

// File: rtl/burst_mode_decode.sv
module burst_mode_decode
   import burst_order_pkg::*;
(
   input  len_mode_e len_mode,
   input  logic      cmd_chop,
   input  logic      cmd_write,
   output logic      chop,
   output logic      early
);

   always_comb begin
      unique case (len_mode)
         LEN_FIX4: chop = 1'b1;
         LEN_OTF:  chop = ~cmd_chop;
         default:  chop = 1'b0;
      endcase
      early = cmd_write & (len_mode == LEN_FIX4);
   end

endmodule

// File: rtl/burst_beat_counter.sv
module burst_beat_counter #(
   parameter int unsigned BEAT_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              busy,
   output logic [BEAT_W-1:0] beat,
   output logic              last
);

   localparam logic [BEAT_W-1:0] BEAT_MAX = {BEAT_W{1'b1}};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy <= 1'b0;
         beat <= '0;
      end else if (start && !busy) begin
         busy <= 1'b1;
         beat <= '0;
      end else if (busy) begin
         if (beat == BEAT_MAX) busy <= 1'b0;
         beat <= beat + 1'b1;
      end
   end

   assign last = busy && (beat == BEAT_MAX);

   a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (busy && beat == '0));

   a_r2_end_on_last: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(last));

endmodule

// File: rtl/burst_col_map.sv
module burst_col_map
   import burst_order_pkg::*;
#(
   parameter int unsigned COL_W    = 3,
   parameter int unsigned GRP_W    = 2,
   parameter bit          INTLV_EN = 1'b1
) (
   input  logic [COL_W-1:0] start_col,
   input  logic [COL_W-1:0] beat,
   input  ord_e             ord,
   input  logic             wr,
   input  logic             chop,
   output logic [COL_W-1:0] col,
   output logic             drive
);

   localparam int unsigned HI_W = COL_W - GRP_W;

   logic [COL_W-1:0] seq_col;
   logic [COL_W-1:0] intlv_col;
   logic [COL_W-1:0] wr_col;
   logic [HI_W-1:0]  grp_sel;

   assign grp_sel = start_col[COL_W-1:GRP_W] ^ beat[COL_W-1:GRP_W];

   assign seq_col[GRP_W-1:0]     = start_col[GRP_W-1:0] + beat[GRP_W-1:0];
   assign seq_col[COL_W-1:GRP_W] = grp_sel;

   generate
      if (INTLV_EN) begin : g_intlv
         for (genvar b = 0; b < COL_W; b++) begin : g_bit
            assign intlv_col[b] = start_col[b] ^ beat[b];
         end
      end else begin : g_seq_only
         assign intlv_col = seq_col;
      end
   endgenerate

   assign wr_col = chop ? {grp_sel, beat[GRP_W-1:0]} : beat;

   always_comb begin
      if (wr)                  col = wr_col;
      else if (ord == ORD_INTLV) col = intlv_col;
      else                     col = seq_col;
      drive = !(chop && (beat[COL_W-1:GRP_W] != '0));
   end

endmodule

// File: rtl/burst_order_gen.sv
module burst_order_gen
   import burst_order_pkg::*;
#(
   parameter int unsigned COL_W    = 3,
   parameter int unsigned GRP_W    = 2,
   parameter bit          INTLV_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             order_sel,
   input  logic [1:0]       len_sel,
   input  logic             cmd_valid,
   input  logic             cmd_write,
   input  logic [COL_W-1:0] cmd_col,
   input  logic             cmd_chop,
   output logic             busy,
   output logic [COL_W-1:0] beat_col,
   output logic             beat_drive,
   output logic             beat_last,
   output logic             wr_early
);

   generate
      if (GRP_W < 1 || COL_W != GRP_W + 1) begin : g_bad_geom
         $error("burst_order_gen: COL_W must equal GRP_W+1 with GRP_W>=1");
      end
   endgenerate

   logic             accept;
   logic             dec_chop;
   logic             dec_early;
   logic [COL_W-1:0] beat_idx;
   logic [COL_W-1:0] map_col;
   logic             map_drive;
   logic [COL_W-1:0] start_q;
   burst_ctx_t       ctx_q;

   assign accept = cmd_valid && !busy;

   burst_mode_decode u_dec (
      .len_mode  (len_mode_e'(len_sel)),
      .cmd_chop  (cmd_chop),
      .cmd_write (cmd_write),
      .chop      (dec_chop),
      .early     (dec_early)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_q <= '0;
         ctx_q   <= '0;
      end else if (accept) begin
         start_q    <= cmd_col;
         ctx_q.wr    <= cmd_write;
         ctx_q.chop  <= dec_chop;
         ctx_q.early <= dec_early;
         ctx_q.ord   <= ord_e'(order_sel);
      end
   end

   burst_beat_counter #(.BEAT_W(COL_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .start (cmd_valid),
      .busy  (busy),
      .beat  (beat_idx),
      .last  (beat_last)
   );

   burst_col_map #(
      .COL_W    (COL_W),
      .GRP_W    (GRP_W),
      .INTLV_EN (INTLV_EN)
   ) u_map (
      .start_col (start_q),
      .beat      (beat_idx),
      .ord       (ctx_q.ord),
      .wr        (ctx_q.wr),
      .chop      (ctx_q.chop),
      .col       (map_col),
      .drive     (map_drive)
   );

   assign beat_col   = busy ? map_col : '0;
   assign beat_drive = busy && map_drive;
   assign wr_early   = busy && ctx_q.early;

   a_r3_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cmd_valid) |=> $stable(start_q));

   a_r9_write_linear: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ctx_q.wr && !ctx_q.chop) |-> (beat_col == beat_idx));

   a_r7_chop_float: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && ctx_q.chop && beat_idx[COL_W-1]) |-> !beat_drive);

   a_r10_early_src: assert property (@(posedge clk) disable iff (!rst_n)
      wr_early |-> (busy && ctx_q.wr && ctx_q.chop));

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!beat_drive && !beat_last && !wr_early));

endmodule

// File: tb/burst_order_gen_tb.sv
module burst_order_gen_tb;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       order_sel = 1'b0;
   logic [1:0] len_sel = 2'b00;
   logic       cmd_valid = 1'b0;
   logic       cmd_write = 1'b0;
   logic [2:0] cmd_col = 3'd0;
   logic       cmd_chop = 1'b0;
   logic       busy;
   logic [2:0] beat_col;
   logic       beat_drive;
   logic       beat_last;
   logic       wr_early;

   int n_tests = 0;
   int n_fail  = 0;
   bit mon_en  = 1'b0;

   typedef struct packed {
      logic [2:0] col;
      logic       drv;
      logic       last;
      logic       early;
      logic       chk_col;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   burst_order_gen u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .order_sel  (order_sel),
      .len_sel    (len_sel),
      .cmd_valid  (cmd_valid),
      .cmd_write  (cmd_write),
      .cmd_col    (cmd_col),
      .cmd_chop   (cmd_chop),
      .busy       (busy),
      .beat_col   (beat_col),
      .beat_drive (beat_drive),
      .beat_last  (beat_last),
      .wr_early   (wr_early)
   );

   task automatic chk(string tag, string what, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // monitor: one expected item per busy beat
   always @(negedge clk) begin
      if (mon_en && rst_n && busy) begin
         if (exp_q.size() == 0) begin
            chk("R2", "unexpected extra beat", 1, 0);
         end else begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (e.chk_col) chk(t, "beat_col", beat_col, e.col);
            chk(t, "beat_drive", beat_drive, e.drv);
            chk(t, "beat_last", beat_last, e.last);
            chk(t, "wr_early", wr_early, e.early);
         end
      end
   end

   function automatic logic [2:0] ref_col(bit wr, bit chop, bit intlv, logic [2:0] s, int i);
      logic [2:0] b;
      b = 3'(i);
      if (wr) return chop ? {s[2], b[1:0]} : b;
      if (intlv) return s ^ b;
      return {s[2] ^ b[2], 2'(s[1:0] + b[1:0])};
   endfunction

   // drive one command, push expectations, check busy drop after 8 beats
   task automatic send(string tag, bit wr, bit intlv, logic [1:0] lsel,
                       bit chop_in, logic [2:0] col, bit intrude);
      bit chop;
      bit early;
      chop  = (lsel == 2'b10) || (lsel == 2'b01 && !chop_in);
      early = wr && (lsel == 2'b10);
      @(negedge clk);
      order_sel = intlv; len_sel = lsel; cmd_write = wr;
      cmd_col = col; cmd_chop = chop_in; cmd_valid = 1'b1;
      for (int i = 0; i < 8; i++) begin
         exp_t e;
         e.col     = ref_col(wr, chop, intlv, col, i);
         e.drv     = !(chop && i >= 4);
         e.last    = (i == 7);
         e.early   = early;
         e.chk_col = !(chop && i >= 4);
         exp_q.push_back(e);
         tag_q.push_back(tag);
      end
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      if (intrude) begin
         @(negedge clk);
         @(negedge clk);
         cmd_valid = 1'b1; cmd_write = !wr; cmd_col = ~col; cmd_chop = !chop_in;
         order_sel = !intlv;
         @(negedge clk);
         cmd_valid = 1'b0;
         repeat (5) @(negedge clk);
      end else begin
         repeat (8) @(negedge clk);
      end
      #1;
      chk(tag, "busy after 8 beats (R2)", busy, 0);
      chk(tag, "queue drained (R2)", exp_q.size(), 0);
      chk("R1", "idle drive", beat_drive, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      chk("watchdog", "run timed out", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", "busy in reset", busy, 0);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R1", "busy after reset", busy, 0);
      chk("R1", "beat_drive after reset", beat_drive, 0);
      chk("R1", "beat_last after reset", beat_last, 0);
      chk("R1", "wr_early after reset", wr_early, 0);
      mon_en = 1'b1;

      send("R4", 0, 0, 2'b00, 0, 3'd5, 0);
      send("R4", 0, 0, 2'b00, 0, 3'd0, 0);
      send("R4", 0, 0, 2'b00, 0, 3'd7, 0);
      send("R5", 0, 1, 2'b00, 0, 3'd5, 0);
      send("R5", 0, 1, 2'b00, 0, 3'd3, 0);
      send("R7", 0, 0, 2'b10, 0, 3'd6, 0);
      send("R7", 0, 1, 2'b10, 0, 3'd1, 0);
      send("R6", 0, 0, 2'b01, 0, 3'd2, 0);
      send("R6", 0, 1, 2'b01, 1, 3'd6, 0);
      send("R6", 0, 0, 2'b11, 0, 3'd3, 0);
      send("R8", 1, 0, 2'b10, 0, 3'd3, 0);
      send("R8", 1, 1, 2'b10, 0, 3'd6, 0);
      send("R10", 1, 0, 2'b01, 0, 3'd7, 0);
      send("R9", 1, 1, 2'b00, 0, 3'd5, 0);
      send("R9", 1, 0, 2'b01, 1, 3'd2, 0);
      send("R3", 0, 0, 2'b00, 0, 3'd1, 1);
      send("R3", 1, 0, 2'b10, 1, 3'd4, 1);

      repeat (3) @(negedge clk);
      chk("R1", "idle at end", busy, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule